// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block follows an HDLC deframer and decides, frame by frame, whether a received frame is addressed to this station. It takes a byte stream that is already stripped of flags, stuffing bits and checksum, with a start marker on the first byte, an end marker on the final byte and an error flag that qualifies the end marker. The first two bytes of each frame form a 16-bit station address. That address is compared under one shared bit mask against four programmable address registers, and the frame is accepted when any of the four agrees.

Accepted frames are forwarded on a registered valid/data/last output, address bytes first, followed by the payload in arrival order. Rejected frames produce no output. A 16-bit counter records how many rejected frames ended without error. Clearing the upper eight mask bits turns the filter into an 8-bit address filter on the first byte only. A simple write port loads the mask, the four addresses and the counter. A start marker that arrives in the middle of a forwarded frame closes the open frame with its error flag set and begins a new one.

Top module: `hdlc_addr_filter`

## Requirements
- R1: The received address is built with the first frame byte (the byte marked by `in_sof`) in bits [7:0] and the second byte in bits [15:8], so bytes 0x68 then 0xAA form 0xAA68.
- R2: The mask is written at `reg_addr` 0. A mask bit of 1 makes that address bit take part in the comparison and a 0 bit ignores it for all four address registers. An all-zero mask accepts every frame of two or more bytes.
- R3: The four address registers are written at `reg_addr` 1, 2, 3 and 4. A frame is accepted when its address agrees with at least one of them under the mask.
- R4: With mask bits [15:8] cleared, only the first frame byte decides acceptance. The second byte has no effect on the decision.
- R5: An accepted frame appears on the output byte for byte in arrival order, both address bytes included, with `out_last` high on the final byte only.
- R6: A rejected frame produces no output byte.
- R7: `rej_count` rises by one for each rejected frame whose end marker comes without `in_err`. A rejected frame that ends with `in_err` leaves it unchanged.
- R8: A frame that ends on its first byte is rejected. It is counted only when it ends without error.
- R9: An accepted frame that ends with `in_err` is still forwarded, with `out_err` high on its final output byte, and `rej_count` does not change.
- R10: `rej_count` wraps from 0xFFFF to 0x0000.
- R11: The counter is written at `reg_addr` 5. That write takes effect only while `enable` is low and is ignored while `enable` is high.
- R12: After reset the mask, the four addresses and `rej_count` are zero, `out_valid` is low, and the block is enabled to accept frames.
- R13: While `enable` is low, input bytes produce no output and do not change `rej_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable; low stops filtering and allows counter writes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 mask, 1-4 addresses, 5 counter |
| reg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Final byte of a frame |
| in_err | input | 1 | Frame ended in error (qualified by `in_eof`) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a forwarded frame |
| out_err | output | 1 | Forwarded frame ended in error (on the final byte) |
| rej_count | output | 16 | Count of error-free rejected frames |

## Verification
The bench sends frames whose two address bytes are swapped, so a design that assembles the address big-endian accepts the wrong one and drops the right one. It loads partial and 8-bit masks chosen so that exactly one address register agrees, which catches an inverted mask sense or an AND instead of an OR across the four comparators. It sends one-byte frames and errored frames on both the accept and reject paths, so a design that counts errored rejects, forwards short frames or loses the error flag on the final byte shows a wrong counter or a wrong output. It also drives the counter to 0xFFFF to check the wrap, tries a counter write while enabled, and feeds frames while disabled, which exposes a counter that saturates, accepts writes at any time, or filters when it should not.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  // Frame tracking states of the stream path
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // waiting for a start-of-frame byte
    ST_ADDR = 2'd1,   // first address byte held, waiting for the second
    ST_PASS = 2'd2,   // frame accepted, forwarding bytes
    ST_DROP = 2'd3    // frame rejected, discarding to end of frame
  } af_state_e;

  // Register select codes; address slots follow the mask
  localparam int unsigned REG_SEL_MASK  = 0;
  localparam int unsigned REG_SEL_ADDR0 = 1;

endpackage

// File: rtl/af_regs.sv
module af_regs #(
  parameter int unsigned AW       = 16,
  parameter int unsigned NUM_ADDR = 4,
  parameter int unsigned CW       = 16,
  parameter int unsigned RAW      = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic                         reg_we,
  input  logic [RAW-1:0]               reg_addr,
  input  logic [AW-1:0]                reg_wdata,
  input  logic                         cnt_inc,
  output logic [AW-1:0]                mask_o,
  output logic [NUM_ADDR-1:0][AW-1:0]  addr_o,
  output logic [CW-1:0]                cnt_o
);
  import hdlc_af_pkg::*;

  localparam int unsigned SEL_CNT = REG_SEL_ADDR0 + NUM_ADDR;

  logic [AW-1:0]               mask_q;
  logic [NUM_ADDR-1:0][AW-1:0] addr_q;
  logic [CW-1:0]               cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (reg_we && reg_addr == RAW'(REG_SEL_MASK)) begin
      mask_q <= reg_wdata;
    end
  end

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[g] <= '0;
      end else if (reg_we && reg_addr == RAW'(REG_SEL_ADDR0 + g)) begin
        addr_q[g] <= reg_wdata;
      end
    end
  end

  // Software may load the counter only while the channel is stopped;
  // increments arrive only while it runs, so the two never collide.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!enable && reg_we && reg_addr == RAW'(SEL_CNT)) begin
      cnt_q <= CW'(reg_wdata);
    end else if (cnt_inc) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign mask_o = mask_q;
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/af_match.sv
module af_match #(
  parameter int unsigned AW       = 16,
  parameter int unsigned NUM_ADDR = 4
) (
  input  logic [AW-1:0]                rx_addr,
  input  logic [AW-1:0]                mask,
  input  logic [NUM_ADDR-1:0][AW-1:0]  addrs,
  output logic                         hit
);

  logic [NUM_ADDR-1:0] slot_hit;

  // One masked comparator per address slot
  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
    assign slot_hit[g] = ((rx_addr ^ addrs[g]) & mask) == '0;
  end

  assign hit = |slot_hit;

endmodule

// File: rtl/af_stream.sv
module af_stream #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_err,
  input  logic          hit,
  output logic [AW-1:0] rx_addr,
  output logic          cnt_inc,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          out_err
);
  import hdlc_af_pkg::*;

  af_state_e     state_q, state_n;
  logic [DW-1:0] first_q, first_n;
  logic          pend_v_q, pend_v_n;
  logic [DW-1:0] pend_d_q, pend_d_n;
  logic          pend_l_q, pend_l_n;
  logic          pend_e_q, pend_e_n;
  logic          ov_q, ov_n;
  logic [DW-1:0] od_q, od_n;
  logic          ol_q, ol_n;
  logic          oe_q, oe_n;

  // Second byte in the upper half, held first byte in the lower half
  assign rx_addr = {in_data, first_q};

  always_comb begin
    state_n  = state_q;
    first_n  = first_q;
    pend_v_n = pend_v_q;
    pend_d_n = pend_d_q;
    pend_l_n = pend_l_q;
    pend_e_n = pend_e_q;
    ov_n     = 1'b0;
    od_n     = od_q;
    ol_n     = 1'b0;
    oe_n     = 1'b0;
    cnt_inc  = 1'b0;

    // A held final byte leaves on the cycle after it was stored
    if (pend_v_q && pend_l_q) begin
      ov_n     = 1'b1;
      od_n     = pend_d_q;
      ol_n     = 1'b1;
      oe_n     = pend_e_q;
      pend_v_n = 1'b0;
    end

    if (!enable) begin
      state_n  = ST_IDLE;
      pend_v_n = 1'b0;
      ov_n     = 1'b0;
      ol_n     = 1'b0;
      oe_n     = 1'b0;
    end else if (in_valid) begin
      if (in_sof) begin
        // New frame while forwarding: close the open one as errored
        if (state_q == ST_PASS && pend_v_q && !pend_l_q) begin
          ov_n     = 1'b1;
          od_n     = pend_d_q;
          ol_n     = 1'b1;
          oe_n     = 1'b1;
          pend_v_n = 1'b0;
        end
        first_n = in_data;
        if (in_eof) begin
          state_n = ST_IDLE;
          cnt_inc = !in_err;
        end else begin
          state_n = ST_ADDR;
        end
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (hit) begin
              ov_n     = 1'b1;
              od_n     = first_q;
              pend_v_n = 1'b1;
              pend_d_n = in_data;
              pend_l_n = in_eof;
              pend_e_n = in_eof && in_err;
              state_n  = in_eof ? ST_IDLE : ST_PASS;
            end else if (in_eof) begin
              state_n = ST_IDLE;
              cnt_inc = !in_err;
            end else begin
              state_n = ST_DROP;
            end
          end
          ST_PASS: begin
            ov_n     = 1'b1;
            od_n     = pend_d_q;
            pend_v_n = 1'b1;
            pend_d_n = in_data;
            pend_l_n = in_eof;
            pend_e_n = in_eof && in_err;
            if (in_eof) state_n = ST_IDLE;
          end
          ST_DROP: begin
            if (in_eof) begin
              state_n = ST_IDLE;
              cnt_inc = !in_err;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      first_q  <= '0;
      pend_v_q <= 1'b0;
      pend_d_q <= '0;
      pend_l_q <= 1'b0;
      pend_e_q <= 1'b0;
      ov_q     <= 1'b0;
      od_q     <= '0;
      ol_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_n;
      first_q  <= first_n;
      pend_v_q <= pend_v_n;
      pend_d_q <= pend_d_n;
      pend_l_q <= pend_l_n;
      pend_e_q <= pend_e_n;
      ov_q     <= ov_n;
      od_q     <= od_n;
      ol_q     <= ol_n;
      oe_q     <= oe_n;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;
  assign out_err   = oe_q;

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int unsigned DW       = 8,
  parameter int unsigned NUM_ADDR = 4,
  parameter int unsigned CW       = 16,
  parameter int unsigned AW       = 2 * DW,
  parameter int unsigned RAW      = $clog2(NUM_ADDR + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_data,
  input  logic           in_sof,
  input  logic           in_eof,
  input  logic           in_err,
  output logic           out_valid,
  output logic [DW-1:0]  out_data,
  output logic           out_last,
  output logic           out_err,
  output logic [CW-1:0]  rej_count
);

  logic [AW-1:0]               mask_w;
  logic [NUM_ADDR-1:0][AW-1:0] addr_w;
  logic [AW-1:0]               rx_addr_w;
  logic                        hit_w;
  logic                        cnt_inc_w;

  af_regs #(
    .AW(AW), .NUM_ADDR(NUM_ADDR), .CW(CW), .RAW(RAW)
  ) regs_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .cnt_inc  (cnt_inc_w),
    .mask_o   (mask_w),
    .addr_o   (addr_w),
    .cnt_o    (rej_count)
  );

  af_match #(
    .AW(AW), .NUM_ADDR(NUM_ADDR)
  ) match_i (
    .rx_addr(rx_addr_w),
    .mask   (mask_w),
    .addrs  (addr_w),
    .hit    (hit_w)
  );

  af_stream #(
    .DW(DW), .AW(AW)
  ) stream_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_err   (in_err),
    .hit      (hit_w),
    .rx_addr  (rx_addr_w),
    .cnt_inc  (cnt_inc_w),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last),
    .out_err  (out_err)
  );

endmodule

// File: rtl/hdlc_af_checker.sv
module hdlc_af_checker #(
  parameter int unsigned DW  = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 16,
  parameter int unsigned RAW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           enable,
  input logic           reg_we,
  input logic [RAW-1:0] reg_addr,
  input logic [AW-1:0]  reg_wdata,
  input logic           in_valid,
  input logic [DW-1:0]  in_data,
  input logic           in_sof,
  input logic           in_eof,
  input logic           in_err,
  input logic           out_valid,
  input logic [DW-1:0]  out_data,
  input logic           out_last,
  input logic           out_err,
  input logic [CW-1:0]  rej_count
);

  AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(enable)); // R13

  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R5

  AST_ERR_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_last); // R9

  AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && rej_count != $past(rej_count))
      |-> rej_count == $past(rej_count) + CW'(1)); // R11

  AST_ERR_FRAME_NOT_COUNTED: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && $past(in_valid) && $past(in_eof) && $past(in_err))
      |-> rej_count == $past(rej_count)); // R7

  AST_COUNT_WRAPS: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && $past(rej_count) == {CW{1'b1}} && rej_count != {CW{1'b1}})
      |-> rej_count == '0); // R10

endmodule

bind hdlc_addr_filter hdlc_af_checker #(
  .DW(DW), .CW(CW), .AW(AW), .RAW(RAW)
) chk_i (.*);

// File: tb/hdlc_addr_filter_tb_top.sv
`timescale 1ns/1ps
module hdlc_addr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_sof;
  logic        in_eof;
  logic        in_err;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_err;
  logic [15:0] rej_count;

  always #10 clk = ~clk;

  hdlc_addr_filter dut_i (
    .clk(clk), .rst(rst), .enable(enable),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_err(out_err), .rej_count(rej_count)
  );

  int checks = 0;
  int fails  = 0;

  // Output monitor: the only writer of the capture arrays
  logic [7:0] cap_d [0:255];
  logic       cap_l [0:255];
  logic       cap_e [0:255];
  int         cap_n = 0;

  always @(negedge clk) begin
    if (out_valid && cap_n < 256) begin
      cap_d[cap_n] = out_data;
      cap_l[cap_n] = out_last;
      cap_e[cap_n] = out_err;
      cap_n = cap_n + 1;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 50000) begin
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
    end
  end

  logic [7:0] fb [0:7];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ld(input logic [7:0] a, input logic [7:0] b,
                    input logic [7:0] c, input logic [7:0] d);
    fb[0] = a; fb[1] = b; fb[2] = c; fb[3] = d;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(input int n, input bit err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fb[i];
      in_sof   = (i == 0);
      in_eof   = (i == n - 1);
      in_err   = err && (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Frame of n bytes from fb, started at capture index st, expected forwarded
  task automatic expect_fwd(input string req, input int st, input int n, input bit err);
    chk(req, "byte count", cap_n - st, n);
    if (cap_n - st == n) begin
      for (int i = 0; i < n; i++) begin
        chk(req, "data", cap_d[st + i], fb[i]);
        chk(req, "last", cap_l[st + i], (i == n - 1));
        chk(req, "err", cap_e[st + i], err && (i == n - 1));
      end
    end
  endtask

  task automatic t_reset();
    int st;
    chk("R12", "out_valid after reset", out_valid, 0);
    chk("R12", "rej_count after reset", rej_count, 0);
    st = cap_n;
    ld(8'h12, 8'h34, 8'h56, 8'h78);
    send(4, 1'b0);
    expect_fwd("R2", st, 4, 1'b0);  // zero mask accepts all (R12 mask reset)
  endtask

  task automatic t_match16();
    int st;
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'hAA68);
    wr(3'd2, 16'hFFFF);
    st = cap_n;
    ld(8'h68, 8'hAA, 8'h44, 8'h01);
    send(4, 1'b0);
    expect_fwd("R1", st, 4, 1'b0);  // little-endian, forwarded in order (R5)
    st = cap_n;
    ld(8'hAA, 8'h68, 8'h44, 8'h01);
    send(4, 1'b0);
    chk("R6", "swapped address dropped", cap_n - st, 0);
    chk("R7", "count after error-free reject", rej_count, 1);
  endtask

  task automatic t_slots();
    int st;
    st = cap_n;
    ld(8'hFF, 8'hFF, 8'h03, 8'h00);
    send(3, 1'b0);
    expect_fwd("R3", st, 3, 1'b0);
    wr(3'd4, 16'h1234);
    st = cap_n;
    ld(8'h34, 8'h12, 8'h00, 8'h00);
    send(2, 1'b0);
    expect_fwd("R3", st, 2, 1'b0);  // two-byte frame, last on byte 2 (R5)
  endtask

  task automatic t_errors();
    int st;
    st = cap_n;
    ld(8'h11, 8'h22, 8'h33, 8'h00);
    send(3, 1'b1);
    chk("R6", "errored reject no output", cap_n - st, 0);
    chk("R7", "errored reject not counted", rej_count, 1);
    st = cap_n;
    ld(8'h68, 8'hAA, 8'h77, 8'h00);
    send(3, 1'b1);
    expect_fwd("R9", st, 3, 1'b1);
    chk("R9", "count after errored accept", rej_count, 1);
  endtask

  task automatic t_short();
    int st;
    st = cap_n;
    ld(8'h68, 8'h00, 8'h00, 8'h00);
    send(1, 1'b0);
    chk("R8", "short frame no output", cap_n - st, 0);
    chk("R8", "short error-free counted", rej_count, 2);
    send(1, 1'b1);
    chk("R8", "short errored not counted", rej_count, 2);
  endtask

  task automatic t_mask8();
    int st;
    wr(3'd0, 16'h00FF);
    wr(3'd1, 16'h0055);
    st = cap_n;
    ld(8'h55, 8'h44, 8'h00, 8'h00);
    send(2, 1'b0);
    expect_fwd("R4", st, 2, 1'b0);
    st = cap_n;
    ld(8'h55, 8'h99, 8'h09, 8'h00);
    send(3, 1'b0);
    expect_fwd("R4", st, 3, 1'b0);
    st = cap_n;
    ld(8'h56, 8'h44, 8'h00, 8'h00);
    send(2, 1'b0);
    chk("R4", "first byte differs dropped", cap_n - st, 0);
    chk("R4", "count after 8-bit reject", rej_count, 3);
  endtask

  task automatic t_partial();
    int st;
    wr(3'd0, 16'hFFF0);
    wr(3'd3, 16'h5670);
    st = cap_n;
    ld(8'h7A, 8'h56, 8'h00, 8'h00);
    send(2, 1'b0);
    expect_fwd("R2", st, 2, 1'b0);  // low nibble ignored
    st = cap_n;
    ld(8'h8A, 8'h56, 8'h00, 8'h00);
    send(2, 1'b0);
    chk("R2", "masked-in bit differs dropped", cap_n - st, 0);
    chk("R7", "count after partial reject", rej_count, 4);
  endtask

  task automatic t_counter();
    wr(3'd5, 16'h1234);
    chk("R11", "write while enabled ignored", rej_count, 4);
    @(negedge clk) enable = 1'b0;
    wr(3'd5, 16'hFFFF);
    chk("R11", "write while disabled", rej_count, 16'hFFFF);
    @(negedge clk) enable = 1'b1;
    ld(8'h8A, 8'h56, 8'h00, 8'h00);
    send(2, 1'b0);
    chk("R10", "counter wraps", rej_count, 0);
  endtask

  task automatic t_disabled();
    int st;
    @(negedge clk) enable = 1'b0;
    st = cap_n;
    ld(8'h7A, 8'h56, 8'h00, 8'h00);
    send(2, 1'b0);
    chk("R13", "no output while disabled", cap_n - st, 0);
    ld(8'h8A, 8'h56, 8'h00, 8'h00);
    send(2, 1'b0);
    chk("R13", "no count while disabled", rej_count, 0);
    @(negedge clk) enable = 1'b1;
    st = cap_n;
    ld(8'h7A, 8'h56, 8'h00, 8'h00);
    send(2, 1'b0);
    expect_fwd("R13", st, 2, 1'b0);  // resumes once enabled
  endtask

  initial begin
    rst = 1'b1; enable = 1'b1;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_match16();
    t_slots();
    t_errors();
    t_short();
    t_mask8();
    t_partial();
    t_counter();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule